// File: doc/BRIEF.md
# Multi-Lane Audio Serial Link Transmitter

This block feeds several one-way serial audio lanes from one narrow host bus. The host writes 24-bit samples a byte at a time. The bytes of a sample come most significant first, and lanes follow one another inside a burst. The block gathers the bytes into samples and puts each finished sample into a small buffer that belongs to its lane. All lanes then shift their samples out together. They share one serial clock, which runs at half the core clock, and one frame-select line. Each lane has its own data line. Every lane carries eight channels per sample period, and each sample sits in a 32-bit slot.

A slot holds the payload, then a flag, then the channel number, then four zero bits. The flag is set when the payload has too many or too few ones. When the flag is set, the payload is XORed with an alternating mask so the line stays near 50% ones. Frame-select is high during the last eight bits of each slot, which lets a receiver find slot edges. A lane whose buffer is empty when a slot starts sends a slot of all zeros and raises a sticky underrun bit.

The sequencer has three states. IDLE holds the serial clock low. START moves from IDLE to LOW once every lane buffer holds a sample, and the first slot is loaded on that move. LOW and HIGH give the two halves of each serial clock period. RISE moves LOW to HIGH. FALL moves HIGH to LOW and either shifts to the next bit or loads the next slot. Each lane buffer holds four samples (96 bits) by default. A write to a full buffer is dropped.

Top module: `audio_lane_tx`

## Requirements
- R1: After reset, sclk_o, fs_o, every sd_o bit and every underrun_o bit are 0.
- R2: A byte is taken on a clock edge where host_sel and host_wr are both 1. Inside a burst, the bytes go lane 0 up to lane LANES-1, three bytes per lane, most significant byte first, and then wrap to lane 0 for the next channel. The sample enters that lane's buffer after its third byte.
- R3: When host_sel is 0, any partly gathered sample is thrown away and the pointer goes back to lane 0, byte 0. A host_wr pulse while host_sel is 0 has no effect.
- R4: sclk_o stays low in IDLE until every lane buffer holds at least one sample. From then on sclk_o toggles on every core clock, starting low, so it runs at half the core rate.
- R5: Each lane sends a 32-bit slot most significant bit first, one bit per sclk_o period. sd_o changes only on a falling edge of sclk_o.
- R6: Slot layout: bits 31:8 carry the payload, bit 7 the inversion flag, bits 6:4 the channel index and bits 3:0 are zero. The channel index is 0 for the first slot after START and then counts 0 to 7 and wraps.
- R7: The inversion flag is 1 when the 24-bit sample has more than 16 or fewer than 8 ones. The payload is then the sample XOR 0x555555. The flag bit itself is never XORed.
- R8: fs_o is 1 during bits 24 to 31 of every slot (the last eight bits sent) and 0 during bits 0 to 23. It is shared by all lanes.
- R9: A lane whose buffer is empty at a slot start sends 32 zero bits in that slot, and its underrun_o bit goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (twice the serial bit rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host burst select; low resets the byte pointer |
| host_wr | input | 1 | Host byte write strobe |
| host_data | input | 8 | Host write byte |
| sclk_o | output | 1 | Shared serial clock |
| fs_o | output | 1 | Shared frame-select |
| sd_o | output | LANES | Serial data, one line per lane |
| underrun_o | output | LANES | Sticky per-lane underrun flag |

## Verification
A wrong byte pointer or a wrong lane pointer puts a payload on the wrong lane or in the wrong byte order. That error shows in the very first serial slot, about 64 core cycles after START. An error in the bit counter or in the channel counter moves the frame-select window or changes bits 6:4 within one slot, so checking fs_o on every rising sclk_o edge finds it within 32 serial bits. A buffer count error shows as a repeated sample, a skipped sample or an early all-zero slot with underrun_o raised. These errors appear at the slot where the count first goes wrong.

// File: rtl/audio_lane_pkg.sv
`timescale 1ns/1ps
package audio_lane_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/host_byte_collector.sv
`timescale 1ns/1ps
module host_byte_collector #(
    parameter int LANES    = 4,
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_sel,
    input  logic                host_wr,
    input  logic [7:0]          host_data,
    output logic [LANES-1:0]    push,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int BPS = SAMPLE_W / 8;
    localparam int BW  = (BPS > 1) ? $clog2(BPS) : 1;
    localparam int LW  = (LANES > 1) ? $clog2(LANES) : 1;

    logic [BW-1:0]       byte_idx;
    logic [LW-1:0]       lane_idx;
    logic [SAMPLE_W-9:0] acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx <= '0;
            lane_idx <= '0;
            acc      <= '0;
            push     <= '0;
            sample   <= '0;
        end else begin
            push <= '0;
            if (!host_sel) begin
                // R3: dropping select abandons any partial sample
                byte_idx <= '0;
                lane_idx <= '0;
            end else if (host_wr) begin
                acc <= {acc[SAMPLE_W-17:0], host_data};
                if (byte_idx == BW'(BPS-1)) begin
                    byte_idx <= '0;
                    sample   <= {acc, host_data};
                    push     <= LANES'(1) << lane_idx;
                    lane_idx <= (lane_idx == LW'(LANES-1)) ? '0 : lane_idx + 1'b1;
                end else begin
                    byte_idx <= byte_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lane_fifo.sv
`timescale 1ns/1ps
module lane_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, do_wr, do_rd;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && (!full || rd_en);
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    // R9: the sequencer must never pop a lane it found empty
    a_r9_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/slot_former.sv
`timescale 1ns/1ps
module slot_former #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32,
    parameter int CH_W     = 3
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CH_W-1:0]     chan,
    input  logic                valid,
    output logic [SLOT_W-1:0]   word
);
    localparam int PAD    = SLOT_W - SAMPLE_W - 1 - CH_W;
    localparam int ONES_W = $clog2(SAMPLE_W + 1);
    localparam int HI_LIM = (SAMPLE_W * 2) / 3;
    localparam int LO_LIM = SAMPLE_W / 3;

    logic [ONES_W-1:0]   ones;
    logic [SAMPLE_W-1:0] mask;
    logic [SAMPLE_W-1:0] payload;
    logic                inv;

    always_comb begin
        ones = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            ones    = ones + ONES_W'(sample[i]);
            mask[i] = (i % 2 == 0);
        end
        // R7: invert when the ones count leaves the middle band
        inv     = (ones > ONES_W'(HI_LIM)) || (ones < ONES_W'(LO_LIM));
        payload = inv ? (sample ^ mask) : sample;
        word    = valid ? {payload, inv, chan, {PAD{1'b0}}} : '0;
    end
endmodule

// File: rtl/audio_lane_tx.sv
`timescale 1ns/1ps
module audio_lane_tx
    import audio_lane_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SAMPLE_W   = 24,
    parameter int SLOT_W     = 32,
    parameter int CH_W       = 3,
    parameter int FIFO_DEPTH = 4,
    parameter int FS_LEN     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic             host_wr,
    input  logic [7:0]       host_data,
    output logic             sclk_o,
    output logic             fs_o,
    output logic [LANES-1:0] sd_o,
    output logic [LANES-1:0] underrun_o
);
    localparam int BW = $clog2(SLOT_W);

    seq_state_t          state, state_nx;
    logic [LANES-1:0]    push, empty, rd_en, underrun;
    logic [SAMPLE_W-1:0] sample;
    logic [SAMPLE_W-1:0] head  [LANES];
    logic [SLOT_W-1:0]   word  [LANES];
    logic [SLOT_W-1:0]   shreg [LANES];
    logic [BW-1:0]       bit_cnt;
    logic [CH_W-1:0]     chan_cnt, load_chan;
    logic                all_ready, last_bit, load;

    host_byte_collector #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) i_collect (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_data(host_data), .push(push), .sample(sample)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) i_fifo (
            .clk(clk), .rst_n(rst_n), .wr_en(push[l]), .wr_data(sample),
            .rd_en(rd_en[l]), .rd_data(head[l]), .empty(empty[l])
        );
        slot_former #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .CH_W(CH_W)) i_form (
            .sample(head[l]), .chan(load_chan), .valid(!empty[l]), .word(word[l])
        );

        // R9: underrun is sticky until reset
        a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $past(underrun[l]) |-> underrun[l]);
    end

    assign all_ready = &(~empty);
    assign last_bit  = (bit_cnt == BW'(SLOT_W-1));
    assign load      = ((state == ST_IDLE) && all_ready) || ((state == ST_HIGH) && last_bit);
    assign load_chan = (state == ST_IDLE) ? '0 : chan_cnt + 1'b1;
    assign rd_en     = {LANES{load}} & ~empty;
    assign underrun_o = underrun;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: START, RISE, FALL
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = all_ready ? ST_LOW : ST_IDLE;
            ST_LOW:  state_nx = ST_HIGH;
            ST_HIGH: state_nx = ST_LOW;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Slot datapath: load on START or at the last FALL, shift on other FALLs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            chan_cnt <= '0;
            underrun <= '0;
            for (int l = 0; l < LANES; l++) shreg[l] <= '0;
        end else if (load) begin
            bit_cnt  <= '0;
            chan_cnt <= load_chan;
            underrun <= underrun | empty;
            for (int l = 0; l < LANES; l++) shreg[l] <= word[l];
        end else if (state == ST_HIGH) begin
            bit_cnt <= bit_cnt + 1'b1;
            for (int l = 0; l < LANES; l++) shreg[l] <= {shreg[l][SLOT_W-2:0], 1'b0};
        end
    end

    // Outputs
    always_comb begin
        sclk_o = (state == ST_HIGH);
        fs_o   = (state != ST_IDLE) && (bit_cnt >= BW'(SLOT_W-FS_LEN));
        for (int l = 0; l < LANES; l++) sd_o[l] = (state != ST_IDLE) && shreg[l][SLOT_W-1];
    end

    // R5: data holds across the rising edge of the serial clock
    a_r5_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sd_o));

    // R8: the frame-select window opens on a falling serial clock edge
    a_r8_fs_opens_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_o) |-> $fell(sclk_o));

    // R6: each slot reload after a running slot advances the channel by one
    a_r6_chan_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HIGH && state == ST_LOW && bit_cnt == '0)
            |-> chan_cnt == $past(chan_cnt) + 1'b1);

    // R4: the serial clock only starts once every lane holds data
    a_r4_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state == ST_LOW) |-> $past(all_ready));
endmodule

// File: tb/test_audio_lane_tx.sv
`timescale 1ns/1ps
module test_audio_lane_tx;
    localparam int LANES = 4;
    localparam int G     = 10;

    // {expected inversion flag, sample}
    localparam logic [24:0] VEC [8] = '{
        {1'b1, 24'h000000}, {1'b1, 24'hFFFFFF}, {1'b0, 24'h0000FF}, {1'b0, 24'h00FFFF},
        {1'b1, 24'h01FFFF}, {1'b1, 24'h00007F}, {1'b0, 24'h123456}, {1'b1, 24'hABCDEF}
    };

    logic clk = 0, rst_n = 0, host_sel = 0, host_wr = 0;
    logic [7:0] host_data = '0;
    logic sclk_o, fs_o;
    logic [LANES-1:0] sd_o, underrun_o;

    int total = 0, bad = 0, rises = 0, fs_bad = 0;
    bit done = 0;
    logic sclk_prev = 0;
    logic [31:0] cap [LANES];

    audio_lane_tx i_audio_lane_tx (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_data(host_data), .sclk_o(sclk_o), .fs_o(fs_o), .sd_o(sd_o),
        .underrun_o(underrun_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int s, int l);
        logic [24:0] v;
        logic [23:0] p;
        if (s >= G) return 32'h0;
        v = VEC[(s * LANES + l) % 8];
        p = v[24] ? (v[23:0] ^ 24'h555555) : v[23:0];
        return {p, v[24], 3'(s % 8), 4'h0};
    endfunction

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        host_sel  = 1;
        host_wr   = 1;
        host_data = b;
    endtask

    task automatic end_burst();
        @(negedge clk);
        host_wr  = 0;
        host_sel = 0;
    endtask

    task automatic write_group(input int g);
        for (int l = 0; l < LANES; l++) begin
            logic [23:0] s;
            s = VEC[(g * LANES + l) % 8][23:0];
            put_byte(s[23:16]);
            put_byte(s[15:8]);
            put_byte(s[7:0]);
        end
        end_burst();
    endtask

    // Serial capture on each rising sclk edge, sampled away from the clock edge
    always @(negedge clk) begin
        if (rst_n && sclk_o && !sclk_prev) begin
            int b, s;
            b = rises % 32;
            s = rises / 32;
            if (fs_o !== (b >= 24)) fs_bad++;
            for (int l = 0; l < LANES; l++) cap[l] = {cap[l][30:0], sd_o[l]};
            if (b == 31 && s <= G + 1) begin
                for (int l = 0; l < LANES; l++) begin
                    if (s < G) chk(cap[l] === exp_word(s, l), "R2 R5 R6 R7 slot", cap[l], exp_word(s, l));
                    else       chk(cap[l] === 32'h0, "R9 zero slot", cap[l], 32'h0);
                end
            end
            rises++;
        end
        sclk_prev = sclk_o;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk({sclk_o, fs_o, sd_o, underrun_o} === '0, "R1 reset outputs",
            32'({sclk_o, fs_o, sd_o, underrun_o}), 32'h0);

        // R3: partial sample abandoned when select drops
        put_byte(8'hAA);
        put_byte(8'hBB);
        end_burst();
        // R3: strobe with select low ignored
        @(negedge clk);
        host_wr = 1; host_data = 8'hCC;
        @(negedge clk);
        host_wr = 0;
        repeat (4) @(negedge clk);
        // R4: serial clock idle while buffers are empty
        chk(sclk_o === 1'b0 && rises == 0, "R4 idle clock", 32'(rises), 32'h0);

        // Vector table walk: prefill, then paced one group per slot
        for (int g = 0; g < G; g++) begin
            if (g >= 3) begin
                wait (rises >= 32 * (g - 2));
                @(negedge clk);
                host_wr = 1; host_data = 8'hEE;   // R3 strobe without select
                @(negedge clk);
                host_wr = 0;
            end
            write_group(g);
            if (g == 0) begin
                repeat (3) @(negedge clk);
                // R4: clock toggles at half the core rate once data is present
                begin
                    logic a, b2;
                    a = sclk_o;
                    @(negedge clk);
                    b2 = sclk_o;
                    chk(a !== b2, "R4 clock toggles", 32'(b2), 32'(~a));
                end
            end
        end

        wait (rises >= 32 * (G - 1) + 8);
        @(negedge clk);
        chk(underrun_o === '0, "R9 no early underrun", 32'(underrun_o), 32'h0);

        wait (rises >= 32 * (G + 2));
        @(negedge clk);
        chk(underrun_o === '1, "R9 sticky underrun", 32'(underrun_o), 32'hF);
        chk(fs_bad == 0, "R8 frame-select window", 32'(fs_bad), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule